// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing side of a byte-wide serial memory with 16384 locations. It samples the two-wire bus lines with a fast system clock and recognises START and STOP conditions. It matches a device-type address byte and loads a 14-bit word pointer from two address bytes. It then carries out byte and multi-byte writes, current-address reads, random reads that begin with a dummy write, and sequential reads. SDA is driven as an open-drain output enable. The storage sits outside the block, behind a port with a combinational read path and a single-cycle write strobe.

A single pointer serves both reads and writes. It advances after every byte that is transferred and wraps from the top of the array to zero. A master can therefore read the location that follows the last one touched, without sending an address. While the `busy_i` input is high, the slave refuses its own address. A master polls with address bytes until one is acknowledged, and that tells it the slow internal update has finished.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe_o` and `mem_we_o` are low.
- R2: The bus lines are resynchronised. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A STOP returns the engine to idle, so bytes clocked after a STOP without a new START get no acknowledge.
- R3: The first byte after a START is the device byte. Its bits 7:4 must equal 4'b1010, bits 3:1 are ignored, and bit 0 set to 1 selects a read while 0 selects a write. On a mismatch the slave gives no acknowledge and ignores the bus until the next START.
- R4: For each byte it receives while addressed, the slave pulls SDA low throughout the ninth SCL high phase.
- R5: After a write-direction device byte, two address bytes follow, high byte first. Bits 7:6 of the high byte are ignored. The pointer is loaded from the 14 bits that remain, and nothing is written.
- R6: Each data byte that follows the address bytes gives one `mem_we_o` pulse of a single cycle at the current pointer. The pointer then advances by one.
- R7: A read returns the byte at the pointer, MSB first, and then advances the pointer. The pointer wraps from 16383 to 0.
- R8: In a read, a master ACK (SDA low in the ninth clock) starts the next byte. A NACK makes the slave release SDA and stay silent until START or STOP.
- R9: While `busy_i` is high, a matching device byte is not acknowledged.
- R10: `sda_oe_o` changes only in the cycle after a detected SCL falling edge, or after a START or STOP.
- R11: A START arriving mid-byte abandons that byte. No write takes place, the pointer is unchanged, and device-byte reception restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| busy_i | input | 1 | Internal update in progress; the device address is refused |
| sda_oe_o | output | 1 | Pull SDA low when high |
| mem_addr_o | output | 14 | Memory pointer, used for both reads and writes |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Combinational read data at `mem_addr_o` |

## Verification
Two things can collide: a write strobe and a START that aborts the transfer. Both are decided by the same bit counter and the same SCL activity. The bench feeds in four bits of a data byte and then a repeated START. It expects the strobe count to stay unchanged, and it expects the read that follows to return the byte at the freshly loaded pointer. That shows the abort took priority and the half-received byte never reached the memory. A stop issued straight after addressing, followed by bytes clocked without any START, checks the other side: the engine must be idle and silent.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_SKIP
  } eng_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int unsigned BIT_W = 4;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edge while SCL held high on both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1; // natural wrap at array top
  end
endmodule

// File: rtl/i2c_mem_engine.sv
module i2c_mem_engine
  import i2c_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              sda_oe_o,
  output logic              ctr_load_o,
  output logic [ADDR_W-1:0] ctr_val_o,
  output logic              ctr_inc_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  eng_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [7:0]       shift_q, tx_q;
  logic [HI_W-1:0]  hi_q;
  logic             ack_q, oe_q;
  logic             last_bit, ack_rise, dev_match, rx_state;
  logic [2:0]       tx_idx;

  assign last_bit  = (bit_q == BIT_W'(8));
  assign ack_rise  = scl_rise_i & last_bit & ~start_i & ~stop_i;
  assign dev_match = (shift_q[7:4] == DEV_TYPE) & ~busy_i;
  assign rx_state  = (state_q == ST_AHI) | (state_q == ST_ALO) | (state_q == ST_WDAT);
  assign tx_idx    = 3'(BIT_W'(7) - bit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      hi_q    <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_DEV;
      bit_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (scl_rise_i && state_q != ST_IDLE && state_q != ST_SKIP) begin
      if (!last_bit) begin
        shift_q <= {shift_q[6:0], sda_i};
        bit_q   <= bit_q + 1'b1;
      end else begin
        bit_q <= '0;
        unique case (state_q)
          ST_DEV: begin
            if (!ack_q) state_q <= ST_SKIP;
            else if (shift_q[0]) begin
              state_q <= ST_RDAT;
              tx_q    <= mem_rdata_i;
            end else state_q <= ST_AHI;
          end
          ST_AHI: begin
            hi_q    <= shift_q[HI_W-1:0];
            state_q <= ST_ALO;
          end
          ST_ALO: state_q <= ST_WDAT;
          ST_RDAT: begin
            if (sda_i) state_q <= ST_SKIP; // master NACK
            else       tx_q    <= mem_rdata_i;
          end
          default: ;
        endcase
      end
    end else if (scl_fall_i) begin
      if (last_bit) begin
        ack_q <= (state_q == ST_DEV) ? dev_match : rx_state;
        oe_q  <= (state_q == ST_DEV) ? dev_match : rx_state;
      end else if (state_q == ST_RDAT) begin
        oe_q <= ~tx_q[tx_idx];
      end else begin
        oe_q <= 1'b0;
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign ctr_load_o  = ack_rise & (state_q == ST_ALO);
  assign ctr_val_o   = {hi_q, shift_q};
  assign mem_we_o    = ack_rise & (state_q == ST_WDAT);
  assign mem_wdata_o = shift_q;
  assign ctr_inc_o   = mem_we_o
                     | (ack_rise & (state_q == ST_DEV) & ack_q & shift_q[0])
                     | (ack_rise & (state_q == ST_RDAT) & ~sda_i);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ctr_load, ctr_inc;
  logic [ADDR_W-1:0] ctr_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_mem_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk_i, .rst_ni,
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .busy_i,
    .mem_rdata_i,
    .sda_oe_o,
    .ctr_load_o  (ctr_load),
    .ctr_val_o   (ctr_val),
    .ctr_inc_o   (ctr_inc),
    .mem_we_o,
    .mem_wdata_o
  );

  i2c_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i, .rst_ni,
    .load_i     (ctr_load),
    .load_val_i (ctr_val),
    .inc_i      (ctr_inc),
    .cnt_o      (mem_addr_o)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              scl_rise_i,
  input logic              scl_fall_i,
  input logic              start_i,
  input logic              stop_i
);
  a_r10_oe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));

  a_r2_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  a_r6_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  a_r6_we_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> scl_rise_i);

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> mem_addr_i == ADDR_W'($past(mem_addr_i) + 1'b1));

  a_r11_no_we_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !mem_we_i);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_i   (sda_oe_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .scl_rise_i (scl_rise),
  .scl_fall_i (scl_fall),
  .start_i    (start_det),
  .stop_i     (stop_det)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam int LOG_N      = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_bus, sda_oe, mem_we;
  logic [13:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0, errors = 0, we_cnt = 0, oe_hi_chg = 0;
  logic oe_prev = 1'b0;
  logic [13:0] log_a [LOG_N];
  logic [7:0]  log_d [LOG_N];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .busy_i(busy),
    .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  function automatic logic [7:0] exp_mem(logic [13:0] a);
    logic [7:0] v = pat(a);
    for (int i = 0; i < LOG_N; i++)
      if (i < log_n && log_a[i] == a) v = log_d[i];
    return v;
  endfunction

  assign mem_rdata = exp_mem(mem_addr);

  always @(posedge clk) begin
    if (mem_we) begin
      we_cnt <= we_cnt + 1;
      if (log_n < LOG_N) begin
        log_a[log_n] <= mem_addr;
        log_d[log_n] <= mem_wdata;
        log_n <= log_n + 1;
      end
    end
  end

  // R10: SDA drive must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe != oe_prev) oe_hi_chg++;
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b;  tick(QTR);
    scl_m = 1'b1; tick(QTR);
    s = sda_bus; tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b1; tick(2*QTR);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~mack, s);
  endtask

  task automatic set_ptr(input logic [15:0] a, input string req);
    logic k;
    bus_start();
    put_byte(8'hA0, k); check({req, " dev ack"}, k, 1);
    put_byte(a[15:8], k); check({req, " hi ack"}, k, 1);
    put_byte(a[7:0], k);  check({req, " lo ack"}, k, 1);
  endtask

  task automatic t_reset();
    check("R1 oe after reset", sda_oe, 0);
    check("R1 we after reset", mem_we, 0);
  endtask

  task automatic t_byte_write();
    logic k; int w0 = we_cnt;
    set_ptr(16'hD234, "R5 R4");
    put_byte(8'hA5, k); check("R4 data ack", k, 1);
    bus_stop();
    check("R6 one strobe", we_cnt - w0, 1);
    check("R5 high bits ignored addr", log_a[log_n-1], 14'h1234);
    check("R6 written data", log_d[log_n-1], 8'hA5);
  endtask

  task automatic t_cur_read();
    logic k; logic [7:0] d;
    bus_start();
    put_byte(8'hA1, k); check("R3 read dev ack", k, 1);
    get_byte(1'b0, d); check("R7 current read", d, exp_mem(14'h1235));
    bus_stop();
  endtask

  task automatic t_random_read();
    logic k; logic [7:0] d; int w0 = we_cnt;
    set_ptr(16'h1234, "R5");
    bus_start();
    put_byte(8'hA1, k); check("R3 restart read ack", k, 1);
    get_byte(1'b0, d); check("R7 random read", d, 8'hA5);
    bus_stop();
    check("R5 dummy write no strobe", we_cnt - w0, 0);
  endtask

  task automatic t_seq_wrap();
    logic k; logic [7:0] d;
    set_ptr(16'h3FFE, "R8");
    bus_start();
    put_byte(8'hA1, k);
    get_byte(1'b1, d); check("R8 seq byte0", d, exp_mem(14'h3FFE));
    get_byte(1'b1, d); check("R8 seq byte1", d, exp_mem(14'h3FFF));
    get_byte(1'b0, d); check("R7 wrap to zero", d, exp_mem(14'h0000));
    get_byte(1'b0, d); check("R8 silent after nack", d, 8'hFF);
    bus_stop();
    bus_start();
    put_byte(8'hA1, k);
    get_byte(1'b0, d); check("R7 pointer after wrap", d, exp_mem(14'h0001));
    bus_stop();
  endtask

  task automatic t_dont_care();
    logic k; logic [7:0] d;
    bus_start();
    put_byte(8'hAE, k); check("R3 dont-care bits ack", k, 1);
    put_byte(8'h00, k); put_byte(8'h10, k);
    put_byte(8'h5A, k); put_byte(8'hC3, k); check("R6 second data ack", k, 1);
    bus_stop();
    set_ptr(16'h0010, "R6");
    bus_start();
    put_byte(8'hAF, k); check("R3 read dont-care ack", k, 1);
    get_byte(1'b1, d); check("R6 byte at base", d, 8'h5A);
    get_byte(1'b0, d); check("R6 byte at base+1", d, 8'hC3);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic k; int w0 = we_cnt;
    bus_start();
    put_byte(8'h90, k); check("R3 mismatch nack", k, 0);
    put_byte(8'h00, k); check("R3 ignored byte", k, 0);
    put_byte(8'h20, k);
    put_byte(8'h77, k); check("R3 ignored data", k, 0);
    bus_stop();
    check("R3 no write", we_cnt - w0, 0);
  endtask

  task automatic t_busy();
    logic k;
    busy = 1'b1;
    bus_start();
    put_byte(8'hA0, k); check("R9 busy nack", k, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    put_byte(8'hA0, k); check("R9 ack after busy", k, 1);
    bus_stop();
  endtask

  task automatic t_abort();
    logic k, s; logic [7:0] d; int w0 = we_cnt;
    set_ptr(16'h0040, "R11");
    for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
    bus_start();
    put_byte(8'hA1, k); check("R11 restart ack", k, 1);
    get_byte(1'b0, d); check("R11 pointer unchanged", d, exp_mem(14'h0040));
    bus_stop();
    check("R11 no strobe on abort", we_cnt - w0, 0);
  endtask

  task automatic t_stop_idle();
    logic k;
    bus_start();
    put_byte(8'hA0, k); check("R2 addressed", k, 1);
    bus_stop();
    put_byte(8'hA0, k); check("R2 idle after stop", k, 0);
    check("R10 no drive change in SCL high", oe_hi_chg, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_byte_write();
    t_cur_read();
    t_random_read();
    t_seq_wrap();
    t_dont_care();
    t_bad_addr();
    t_busy();
    t_abort();
    t_stop_idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule